// File: doc/BRIEF.md
# Start-Up and Fault Sequencer for a Resonant LED Driver

This block is the supervisory state machine of a resonant LED driver controller. It reads digitized comparator flags: supply good, backlight enable, overvoltage, undervoltage, over-temperature, and two current-limit levels. From these it decides when the power stage may switch, when the soft-start ramp may rise, and when the LED switch and dimming path may act. A hold timer gives a fixed settling delay before every start attempt. A second counter stands in for the soft-start ramp and marks its completion.

The block sorts faults by the response they get. Overvoltage, over-temperature and the lower current limit shut the stage down. Once the fault clears, the block waits through the hold delay and then retries. Undervoltage is ignored until soft start finishes, so the output capacitors can charge; after that it causes the same retry. The upper current limit latches the block off, and only a loss of supply releases it. Every comparator input passes through a multi-flop synchronizer before the state machine sees it.

Top module: `led_seq_supervisor`

## Requirements
- R1: While `supply_ok_i` or `bl_enable_i` is low, the outputs sit in the idle pattern: `gate_reset_o`=1, and `ss_run_o`, `led_permit_o`, `ss_end_o` and `latched_o` all 0. This pattern also holds after `rst_n` is released.
- R2: When supply and enable are both high, `gate_reset_o` stays high through the input synchronizer and then for `HOLD_CYC` cycles of hold delay. It falls `HOLD_CYC`+3 clock edges after the enable input changes. `ss_run_o` rises on that same edge.
- R3: `ss_end_o` and `led_permit_o` rise exactly `SS_CYC` clock edges after `gate_reset_o` falls. At that edge `ss_run_o` stays high and `gate_reset_o` stays low.
- R4: While the block is in the hold delay or the soft-start ramp, an active `uvp_i` has no effect. The ramp runs on and `ss_end_o` rises on time.
- R5: Any of `ovp_i`, `otp_i` or `ilim_lo_i` going active forces the pattern `gate_reset_o`=1 with `ss_run_o`, `led_permit_o` and `ss_end_o` all 0. This happens 3 clock edges after the input changes.
- R6: `gate_reset_o` stays high for as long as any of those three faults is active. It falls `HOLD_CYC`+2 edges after the last one clears, and a full soft start then follows.
- R7: Once `ss_end_o` is high, an active `uvp_i` shuts the stage down 3 edges later. `gate_reset_o` then stays high for exactly `HOLD_CYC` edges, and a new soft start follows.
- R8: `ilim_hi_i` going active sets `latched_o`=1 and `gate_reset_o`=1 3 edges later. This takes priority over every other path. The latched state stays while supply is good, even if faults clear or enable toggles.
- R9: Only a low `supply_ok_i` clears `latched_o`, 3 edges after the supply drops. When supply returns, a normal start follows with the R2 timing.
- R10: A low `bl_enable_i` or `supply_ok_i` returns the block to the idle pattern 3 edges later, from any active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Supply above its turn-on level (asynchronous) |
| bl_enable_i | input | 1 | Backlight enable (asynchronous) |
| ovp_i | input | 1 | Output overvoltage flag |
| uvp_i | input | 1 | Output undervoltage flag |
| otp_i | input | 1 | Over-temperature flag |
| ilim_lo_i | input | 1 | Lower current-limit flag (auto-restart) |
| ilim_hi_i | input | 1 | Upper current-limit flag (latch-off) |
| gate_reset_o | output | 1 | High disables gate drive and LED switch |
| ss_run_o | output | 1 | Soft-start ramp enable; low discharges it |
| led_permit_o | output | 1 | LED switch and dimming path allowed |
| ss_end_o | output | 1 | Soft start complete; undervoltage check armed |
| latched_o | output | 1 | Latch-off fault active |

## Verification
A wrong state shows up quickly at the ports because each state drives its own output pattern. A state stuck in the hold delay keeps `gate_reset_o` high beyond its expected edge. A state that enters the run phase early raises `ss_end_o` before its expected edge. The bench therefore measures every edge-count latency exactly: 3 edges for a shutdown, `HOLD_CYC`+2 or +3 edges for a release, `SS_CYC` edges for the ramp. An error of one cycle in a timer, or a missing synchronizer stage, fails the test at once. Masked undervoltage and the latch are checked by holding the offending input active across the window where a faulty design would react.

// File: rtl/ledsup_pkg.sv
package ledsup_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_HOLD  = 3'd1,
      ST_RAMP  = 3'd2,
      ST_RUN   = 3'd3,
      ST_LATCH = 3'd4
   } sup_state_t;

   localparam int unsigned FLAG_N  = 7;
   localparam int unsigned F_SUP   = 0;
   localparam int unsigned F_EN    = 1;
   localparam int unsigned F_OV    = 2;
   localparam int unsigned F_UV    = 3;
   localparam int unsigned F_OT    = 4;
   localparam int unsigned F_ILO   = 5;
   localparam int unsigned F_IHI   = 6;
endpackage

// File: rtl/ledsup_sync.sv
module ledsup_sync #(
   parameter int unsigned WIDTH  = 7,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= async_i;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[g] <= '0;
         else        chain[g] <= chain[g-1];
      end
   end

   assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/ledsup_timer.sv
module ledsup_timer #(
   parameter int unsigned LIMIT = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   output logic done_o
);
   localparam int unsigned CW   = (LIMIT < 2) ? 1 : $clog2(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   assign done_o = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (clr_i)            cnt <= '0;
      else if (run_i && !done_o) cnt <= cnt + 1'b1;
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);                                                 // R2
   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt == '0));                                       // R3
endmodule

// File: rtl/led_seq_supervisor.sv
module led_seq_supervisor
   import ledsup_pkg::*;
#(
   parameter int unsigned HOLD_CYC    = 500000,
   parameter int unsigned SS_CYC      = 200000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok_i,
   input  logic bl_enable_i,
   input  logic ovp_i,
   input  logic uvp_i,
   input  logic otp_i,
   input  logic ilim_lo_i,
   input  logic ilim_hi_i,
   output logic gate_reset_o,
   output logic ss_run_o,
   output logic led_permit_o,
   output logic ss_end_o,
   output logic latched_o
);
   if (HOLD_CYC < 2)    begin : g_bad_hold  $error("HOLD_CYC must be at least 2");    end
   if (SS_CYC < 2)      begin : g_bad_ss    $error("SS_CYC must be at least 2");      end
   if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end

   logic [FLAG_N-1:0] raw, flg;
   sup_state_t        st, st_nxt;
   logic              hold_done, ramp_done;
   logic              sup_s, en_s, uv_s, hi_s, auto_s;

   assign raw[F_SUP] = supply_ok_i;
   assign raw[F_EN]  = bl_enable_i;
   assign raw[F_OV]  = ovp_i;
   assign raw[F_UV]  = uvp_i;
   assign raw[F_OT]  = otp_i;
   assign raw[F_ILO] = ilim_lo_i;
   assign raw[F_IHI] = ilim_hi_i;

   ledsup_sync #(.WIDTH(FLAG_N), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(flg));

   assign sup_s  = flg[F_SUP];
   assign en_s   = flg[F_EN];
   assign uv_s   = flg[F_UV];
   assign hi_s   = flg[F_IHI];
   assign auto_s = flg[F_OV] | flg[F_OT] | flg[F_ILO];

   ledsup_timer #(.LIMIT(HOLD_CYC)) hold_tmr_i (
      .clk(clk), .rst_n(rst_n),
      .clr_i((st != ST_HOLD) || auto_s),
      .run_i(st == ST_HOLD),
      .done_o(hold_done));

   ledsup_timer #(.LIMIT(SS_CYC)) ramp_tmr_i (
      .clk(clk), .rst_n(rst_n),
      .clr_i(st != ST_RAMP),
      .run_i(st == ST_RAMP),
      .done_o(ramp_done));

   always_comb begin
      st_nxt = st;
      if (!sup_s)                          st_nxt = ST_IDLE;
      else if (st == ST_LATCH || hi_s)     st_nxt = ST_LATCH;
      else if (!en_s)                      st_nxt = ST_IDLE;
      else begin
         unique case (st)
            ST_IDLE: st_nxt = ST_HOLD;
            ST_HOLD: if (!auto_s && hold_done) st_nxt = ST_RAMP;
            ST_RAMP: if (auto_s)               st_nxt = ST_HOLD;
                     else if (ramp_done)       st_nxt = ST_RUN;
            ST_RUN:  if (auto_s || uv_s)       st_nxt = ST_HOLD;
            default:                           st_nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nxt;
   end

   assign gate_reset_o = (st != ST_RAMP) && (st != ST_RUN);
   assign ss_run_o     = (st == ST_RAMP) || (st == ST_RUN);
   assign led_permit_o = (st == ST_RUN);
   assign ss_end_o     = (st == ST_RUN);
   assign latched_o    = (st == ST_LATCH);

   AST_FAULT_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (sup_s && en_s && auto_s && !hi_s && !latched_o) |=> gate_reset_o);         // R5
   AST_UV_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_run_o && !ss_end_o && uv_s && !auto_s && sup_s && en_s && !hi_s)
         |=> !gate_reset_o);                                                     // R4
   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (latched_o && sup_s) |=> latched_o);                                       // R8
   AST_SUPPLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !sup_s |=> (gate_reset_o && !latched_o && !ss_run_o));                     // R9
   AST_END_AFTER_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_end_o) |-> ($past(ss_run_o) && $past(ramp_done)));                // R3
   AST_HOLD_ELAPSED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_reset_o) |-> $past(hold_done));                                 // R2
endmodule

// File: tb/led_seq_supervisor_tb_top.sv
module led_seq_supervisor_tb_top;
   localparam int HOLD = 20;
   localparam int SS   = 12;

   localparam logic [4:0] P_IDLE  = 5'b10000;
   localparam logic [4:0] P_HOLD  = 5'b10000;
   localparam logic [4:0] P_RAMP  = 5'b01000;
   localparam logic [4:0] P_RUN   = 5'b01110;
   localparam logic [4:0] P_LATCH = 5'b10001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sup = 0, en = 0, ov = 0, uv = 0, ot = 0, ilo = 0, ihi = 0;
   logic gr, ssr, perm, sse, lat;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   typedef struct {
      string      tag;
      logic [4:0] pat;
   } exp_t;
   exp_t exp_q[$];
   event snap_ev;

   always #10 clk = ~clk;

   led_seq_supervisor #(.HOLD_CYC(HOLD), .SS_CYC(SS), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .supply_ok_i(sup), .bl_enable_i(en), .ovp_i(ov), .uvp_i(uv),
      .otp_i(ot), .ilim_lo_i(ilo), .ilim_hi_i(ihi),
      .gate_reset_o(gr), .ss_run_o(ssr), .led_permit_o(perm),
      .ss_end_o(sse), .latched_o(lat));

   // monitor: pops expected output patterns and compares them
   initial begin
      forever begin
         @(snap_ev);
         while (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            checks++;
            if ({gr, ssr, perm, sse, lat} !== it.pat) begin
               errors++;
               $display("FAIL %s: outputs %b expected %b", it.tag,
                        {gr, ssr, perm, sse, lat}, it.pat);
            end
         end
      end
   end

   task automatic expect_pat(input string tag, input logic [4:0] p);
      exp_t it;
      it.tag = tag;
      it.pat = p;
      exp_q.push_back(it);
      ->snap_ev;
      #0;
   endtask

   task automatic check_int(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic logic pick(input int sel);
      case (sel)
         0: return gr;
         1: return sse;
         default: return lat;
      endcase
   endfunction

   task automatic edges_until(input int sel, input logic val, output int n);
      n = 0;
      do begin
         @(posedge clk);
         @(negedge clk);
         n++;
      end while (pick(sel) !== val && n < 1000);
   endtask

   task automatic idle(input int k);
      repeat (k) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic reach_run(input string tag);
      int n;
      edges_until(0, 1'b0, n);
      edges_until(1, 1'b1, n);
      check_int({tag, " ramp length"}, n, SS);
   endtask

   initial begin
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      expect_pat("R1 after reset", P_IDLE);

      sup = 1;
      idle(10);
      expect_pat("R1 supply without enable", P_IDLE);

      // start-up timing
      en = 1;
      edges_until(0, 1'b0, n);
      check_int("R2 hold release from enable", n, HOLD + 3);
      expect_pat("R2 ramp begins", P_RAMP);
      edges_until(1, 1'b1, n);
      check_int("R3 ramp length", n, SS);
      expect_pat("R3 run pattern", P_RUN);

      // overvoltage with undervoltage masked during the retry
      ov = 1;
      edges_until(0, 1'b1, n);
      check_int("R5 ovp shutdown latency", n, 3);
      expect_pat("R5 ovp shutdown pattern", P_HOLD);
      uv = 1;
      idle(HOLD + 10);
      expect_pat("R6 reset held during fault", P_HOLD);
      ov = 0;
      edges_until(0, 1'b0, n);
      check_int("R6 release after ovp clears", n, HOLD + 2);
      idle(SS - 4);
      expect_pat("R4 uv ignored in ramp", P_RAMP);
      uv = 0;
      edges_until(1, 1'b1, n);
      check_int("R4 ramp end unaffected by uv", n, 4);

      // over-temperature
      ot = 1;
      edges_until(0, 1'b1, n);
      check_int("R5 otp shutdown latency", n, 3);
      ot = 0;
      edges_until(0, 1'b0, n);
      check_int("R6 release after otp clears", n, HOLD + 2);
      edges_until(1, 1'b1, n);
      check_int("R6 soft start repeats", n, SS);

      // lower current limit
      ilo = 1;
      edges_until(0, 1'b1, n);
      check_int("R5 ilim_lo shutdown latency", n, 3);
      expect_pat("R5 ilim_lo pattern", P_HOLD);
      ilo = 0;
      reach_run("R6 ilim_lo");

      // undervoltage after soft start
      uv = 1;
      edges_until(0, 1'b1, n);
      check_int("R7 uv shutdown latency", n, 3);
      expect_pat("R7 uv shutdown pattern", P_HOLD);
      uv = 0;
      edges_until(0, 1'b0, n);
      check_int("R7 hold after uv", n, HOLD);
      edges_until(1, 1'b1, n);
      check_int("R7 ramp after uv", n, SS);

      // enable drop mid-ramp
      ov = 1;
      idle(5);
      ov = 0;
      edges_until(0, 1'b0, n);
      idle(3);
      en = 0;
      edges_until(0, 1'b1, n);
      check_int("R10 enable loss latency", n, 3);
      expect_pat("R10 enable loss idle", P_IDLE);
      en = 1;
      edges_until(0, 1'b0, n);
      check_int("R2 restart after enable", n, HOLD + 3);
      edges_until(1, 1'b1, n);
      check_int("R3 ramp after enable", n, SS);

      // latch-off
      ihi = 1;
      edges_until(2, 1'b1, n);
      check_int("R8 latch latency", n, 3);
      expect_pat("R8 latch pattern", P_LATCH);
      ihi = 0;
      ov = 1;
      idle(5);
      ov = 0;
      en = 0;
      idle(5);
      en = 1;
      idle(HOLD + SS + 10);
      expect_pat("R8 latch persists", P_LATCH);

      sup = 0;
      edges_until(2, 1'b0, n);
      check_int("R9 supply loss clears latch", n, 3);
      expect_pat("R9 idle after supply loss", P_IDLE);
      sup = 1;
      edges_until(0, 1'b0, n);
      check_int("R9 normal start after supply", n, HOLD + 3);
      edges_until(1, 1'b1, n);
      check_int("R9 ramp after supply", n, SS);

      // supply loss from run
      sup = 0;
      edges_until(0, 1'b1, n);
      check_int("R10 supply loss latency", n, 3);
      expect_pat("R10 supply loss idle", P_IDLE);

      idle(5);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule